// File: doc/BRIEF.md
# Two-Source Non-Maskable Interrupt Combiner

This block merges two non-maskable interrupt requests into a single registered, active-low NMI line for a processor. One request comes from a mechanical push button. Its raw level is brought into the clock domain by a synchronizer and then filtered by a stability counter. A rising edge of the filtered level sets a sticky pending bit, so a short press becomes a persistent request. The other request is a level from a bus bridge that reports bus system errors and I/O-check conditions. It is forwarded without latching or filtering, and it is cleared at its origin, not here.

Software sees a 32-bit status word with one pending flag per source. It clears the button's pending bit by writing a one to bit 0 of an acknowledge word. Each register sits on its own 64-bit boundary, and the three low address bits are not decoded, so one word address serves both byte orders. Reads return data in the same cycle. Writes take effect at the clock edge.

Top module: `nmi_agg`

## Requirements
- R1: After reset, with both requests inactive, `nmi_n` is 1 and the status word reads 0.
- R2: The button level must stay stable at the synchronizer output for DEB_CYCLES consecutive clocks before it is accepted. A press shorter than that leaves the pending bit clear.
- R3: An accepted press sets the button pending bit. The bit stays set after the button is released, until it is acknowledged.
- R4: The bridge request is not latched. Status bit 1 equals the `bridge_nmi` input in the same cycle, and it clears when the input drops.
- R5: `nmi_n` is registered and active low. At each clock edge it takes the inverse of (button pending OR `bridge_nmi`), so it changes one clock after either request changes.
- R6: The status word sits at byte offset 0x00. Bit 0 is button pending, bit 1 is bridge pending, and bits 31:2 read 0. Any address outside the status word reads 0.
- R7: A write to byte offset 0x08 with data bit 0 = 1 clears button pending. A write there with bit 0 = 0, or a write to any other offset, changes nothing.
- R8: Address bits [2:0] are not decoded. Any byte address from 0x00 to 0x07 reads status, and any address from 0x08 to 0x0F acknowledges.
- R9: If an accepted press edge and an acknowledge write fall in the same clock, the pending bit stays set.
- R10: Only the rising edge of the filtered button level sets the pending bit. A button held down after an acknowledge does not set it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Raw push-button level, asynchronous, 1 = pressed |
| bridge_nmi | input | 1 | Bridge NMI request level, synchronous, 1 = active |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| nmi_n | output | 1 | Registered active-low NMI to the CPU |

## Verification
The button path is driven in three ways. A press shorter than the filter window shows that glitches are rejected. A press held past the window shows that the request is accepted and then kept after release. A press held through an acknowledge shows that only the edge sets the latch, not the level. An acknowledge timed to the exact clock of the press edge tells set-over-clear priority apart from the reverse. A random phase toggles the bridge request and mixes harmless writes with real acknowledges at random low address bits, to separate pass-through behaviour from latched behaviour and decoded bits from ignored ones.

// File: rtl/nmi_agg_pkg.sv
package nmi_agg_pkg;
   // Number of low address bits left out of register decode (64-bit slots).
   localparam int unsigned SLOT_LSB = 3;

   typedef struct packed {
      logic bridge;
      logic button;
   } nmi_src_t;

   function automatic logic [1:0] pack_src(input nmi_src_t s);
      return {s.bridge, s.button};
   endfunction
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nmi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_debounce.sv
module nmi_debounce #(
   parameter int unsigned CYCLES = 65536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   if (CYCLES < 2) begin : g_bad_cycles
      $error("nmi_debounce: CYCLES must be at least 2");
   end

   localparam int unsigned CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(CYCLES - 1);

   logic [CW-1:0] run_q;
   logic          level_q;
   logic          differs;
   logic          accept;

   assign differs = (din != level_q);
   assign accept  = differs && (run_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         level_q <= 1'b0;
      end else if (!differs) begin
         run_q <= '0;
      end else if (accept) begin
         run_q   <= '0;
         level_q <= din;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign level = level_q;
   assign rise  = accept && din;
endmodule

// File: rtl/nmi_sticky.sv
module nmi_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend_q <= 1'b0;
      else if (set) pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
   end

   assign pend = pend_q;
endmodule

// File: rtl/nmi_agg.sv
module nmi_agg
   import nmi_agg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DEB_CYCLES  = 65536,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STATUS_OFS  = 'h00,
   parameter int unsigned ACK_OFS     = 'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              btn_raw,
   input  logic              bridge_nmi,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              nmi_n
);
   if (ADDR_W <= SLOT_LSB) begin : g_bad_addr
      $error("nmi_agg: ADDR_W too small for slot decode");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("nmi_agg: DATA_W must hold both flags");
   end
   if ((STATUS_OFS % 8) != 0 || (ACK_OFS % 8) != 0 || STATUS_OFS == ACK_OFS) begin : g_bad_ofs
      $error("nmi_agg: offsets must be distinct and 64-bit aligned");
   end

   localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
   localparam logic [ADDR_W-1:0] ACK_A    = ADDR_W'(ACK_OFS);

   logic     btn_sync;
   logic     deb_level;
   logic     set_pulse;
   logic     ack_hit;
   logic     status_hit;
   logic     btn_pend;
   logic     nmi_n_q;
   nmi_src_t src;

   nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(btn_raw), .dout(btn_sync)
   );

   nmi_debounce #(.CYCLES(DEB_CYCLES)) u_deb (
      .clk(clk), .rst_n(rst_n), .din(btn_sync),
      .level(deb_level), .rise(set_pulse)
   );

   assign status_hit = (bus_addr[ADDR_W-1:SLOT_LSB] == STATUS_A[ADDR_W-1:SLOT_LSB]);
   assign ack_hit    = bus_wr && bus_wdata[0] &&
                       (bus_addr[ADDR_W-1:SLOT_LSB] == ACK_A[ADDR_W-1:SLOT_LSB]);

   nmi_sticky u_latch (
      .clk(clk), .rst_n(rst_n), .set(set_pulse), .clr(ack_hit), .pend(btn_pend)
   );

   assign src.button = btn_pend;
   assign src.bridge = bridge_nmi;

   always_comb begin
      bus_rdata = '0;
      if (status_hit) bus_rdata[1:0] = pack_src(src);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nmi_n_q <= 1'b1;
      else        nmi_n_q <= ~(src.button | src.bridge);
   end

   assign nmi_n = nmi_n_q;
endmodule

// File: rtl/nmi_agg_chk.sv
module nmi_agg_chk (
   input logic clk,
   input logic rst_n,
   input logic bridge_nmi,
   input logic btn_sync,
   input logic deb_level,
   input logic set_pulse,
   input logic ack_hit,
   input logic btn_pend,
   input logic nmi_n
);
   logic armed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   assert_nmi_out_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      nmi_n == !($past(btn_pend) || $past(bridge_nmi)));

   assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      set_pulse |=> btn_pend);

   assert_set_beats_ack_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      (set_pulse && ack_hit) |=> btn_pend);

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      (ack_hit && !set_pulse) |=> !btn_pend);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      (!ack_hit && !set_pulse) |=> $stable(btn_pend));

   assert_filter_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      !$stable(deb_level) |-> deb_level == $past(btn_sync));
endmodule

bind nmi_agg nmi_agg_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bridge_nmi(bridge_nmi), .btn_sync(btn_sync),
   .deb_level(deb_level), .set_pulse(set_pulse), .ack_hit(ack_hit),
   .btn_pend(btn_pend), .nmi_n(nmi_n)
);

// File: tb/nmi_agg_tb.sv
module nmi_agg_tb;
   localparam int DEB = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        btn_raw = 1'b0;
   logic        bridge_nmi = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        nmi_n;

   int checks = 0;
   int errors = 0;
   bit exp_pend = 1'b0;

   always #2.5 clk = ~clk;

   nmi_agg #(.DEB_CYCLES(DEB)) u_dut (
      .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .bridge_nmi(bridge_nmi),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .nmi_n(nmi_n)
   );

   function automatic logic [31:0] exp_status(input bit p, input bit b);
      return {30'd0, b, p};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd_status(input string req, input logic [2:0] lo);
      bus_wr = 1'b0;
      bus_addr = {5'd0, lo};
      #0.5;
      chk(req, bus_rdata, exp_status(exp_pend, bridge_nmi));
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      cyc(1);
      bus_wr = 1'b0;
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R1 reset state
      chk("R1 nmi_n", nmi_n, 1);
      rd_status("R1 status", 3'd0);

      // R2 short press rejected
      btn_raw = 1'b1; cyc(DEB - 2); btn_raw = 1'b0; cyc(DEB + 4);
      rd_status("R2 glitch", 3'd0);
      chk("R2 nmi_n", nmi_n, 1);

      // R3 accepted press persists after release
      btn_raw = 1'b1; cyc(DEB + 4); btn_raw = 1'b0; cyc(DEB + 4);
      exp_pend = 1'b1;
      rd_status("R3 latched", 3'd5);
      chk("R3/R5 nmi_n", nmi_n, 0);

      // R7 ack with bit0=0 ignored, other address ignored
      wr(8'h08, 32'hFFFF_FFFE); rd_status("R7 bit0 zero", 3'd0);
      wr(8'h10, 32'h1);         rd_status("R7 other addr", 3'd0);
      wr(8'h00, 32'h1);         rd_status("R7 status write", 3'd0);
      // R8 ack with nonzero low bits clears
      wr(8'h0D, 32'h1); exp_pend = 1'b0;
      rd_status("R8 ack low bits", 3'd7);
      cyc(1);
      chk("R5 nmi_n released", nmi_n, 1);
      bus_addr = 8'h40; #0.5;
      chk("R6 unmapped read", bus_rdata, 0);

      // R10 held button: ack while held, no re-set
      btn_raw = 1'b1; cyc(DEB + 4);
      exp_pend = 1'b1; rd_status("R10 set", 3'd0);
      wr(8'h08, 32'h1); exp_pend = 1'b0; cyc(DEB + 4);
      rd_status("R10 held no reset", 3'd0);
      btn_raw = 1'b0; cyc(DEB + 4);

      // R9 ack coincident with press edge (edge at posedge DEB+2 after drive)
      btn_raw = 1'b1;
      cyc(DEB + 1);
      bus_addr = 8'h08; bus_wdata = 32'h1; bus_wr = 1'b1;
      cyc(1);
      bus_wr = 1'b0;
      exp_pend = 1'b1;
      rd_status("R9 set wins", 3'd0);
      btn_raw = 1'b0; cyc(DEB + 4);

      // R4 bridge pass-through, random phase
      void'($urandom(32'd1234));
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom % 5);
         case (op)
            0: begin bridge_nmi = ~bridge_nmi; rd_status("R4 bridge follows", 3'($urandom)); end
            1: wr(8'h10 + 8'($urandom % 240), 32'($urandom) | 32'h1);
            2: wr(8'h08 | 8'($urandom % 8), 32'($urandom) & 32'hFFFF_FFFE);
            3: begin wr(8'h08 | 8'($urandom % 8), 32'h1); exp_pend = 1'b0; end
            default: begin
               btn_raw = 1'b1; cyc(DEB + 4); btn_raw = 1'b0; cyc(DEB + 4);
               exp_pend = 1'b1;
            end
         endcase
         cyc(1);
         chk("R5 nmi_n", nmi_n, !(exp_pend || bridge_nmi));
         rd_status("R6 status", 3'($urandom));
      end
      bridge_nmi = 1'b0; #0.5;
      rd_status("R4 bridge drop", 3'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule